// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter for periodic events. A prescale counter advances on every clock while counting is enabled. Each time it reaches the programmed prescale value it wraps to zero and emits a tick, and that tick advances the main timer counter. The timer therefore steps once every PR+1 clocks. Both counters are 32 bits wide, and software can read and write them at any time over a simple word-addressed register bus.

Seven match registers are compared against the timer count. A match event occurs when a prescale tick arrives while the timer count equals a match register. Every match event produces a one-clock strobe on its own output bit, and a downstream waveform stage uses these strobes. Three control bits per match register choose what else the event does: latch a pending interrupt flag, restart the timer from zero, or halt counting. Pending flags are cleared by writing ones. The interrupt output is high while any flag is pending.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `match_pulse` is all zeros.
- R2: While counting is enabled, the prescale counter steps by one each clock. On the clock where it is at or above the prescale value (word 3), it wraps to 0 and the timer counter (word 2) steps by one. The timer therefore advances once every PR+1 clocks and wraps from all ones to zero.
- R3: While control bit 0 (word 1) is low, neither counter changes except through a bus write.
- R4: While control bit 1 is high, both counters read zero and bus writes to them have no effect.
- R5: A bus write to the timer counter (word 2) or the prescale counter (word 4) replaces its value at that clock edge, taking priority over counting. A read returns the register combinationally while `bus_sel` is high and `bus_wr` is low.
- R6: When a prescale tick occurs while the timer equals match register i (word 8+i), `match_pulse[i]` is high for exactly the following clock. This happens whatever the control bits are set to.
- R7: Match-control (word 5) bit 3i enables the interrupt action. A match event of register i with this bit set makes flag bit i of word 0 go high, and `irq` is high while any flag bit is high.
- R8: Writing word 0 clears each flag whose written bit is 1 and leaves flags written with 0 unchanged. A flag that is set and cleared at the same edge stays set.
- R9: Match-control bit 3i+1 enables the restart action. At the tick of such a match event the timer loads 0 instead of incrementing, which gives a period of MRi+1 timer steps.
- R10: Match-control bit 3i+2 enables the halt action. At the event, control bit 0 clears, and the timer keeps the match value unless a restart action applies at the same event. The prescale counter has wrapped to 0 at that point.
- R11: Unused register bits read zero: control keeps 2 bits, match-control keeps 21 bits and flags keep 7 bits. Word addresses 6, 7 and 15 and above read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | OR of pending match flags |
| match_pulse | output | 7 | One-clock match event strobes |

## Verification
All register writes land at the first rising edge after they are driven. Reads are combinational, so the bench issues a read between edges once the write has completed. A counter state after n enabled edges is due immediately after the n-th edge: timer = floor(n/(PR+1)), prescale = n mod (PR+1), adjusted for restart or halt. The bench counts edges exactly from the edge that enables the timer. Match strobes and flags are registered one level behind the tick, so for a timer step at edge k they are sampled after edge k and compared against a cycle index that the bench computes itself. Every sample is taken at the falling clock edge.

// File: rtl/mtmr_pkg.sv
// Shared constants for the prescaled match timer: word addresses of the
// register bus and the layout of the per-match action bits.
// Assumes a word-addressed bus at least 5 bits wide.
package mtmr_pkg;
    localparam int unsigned A_FLAGS   = 0;
    localparam int unsigned A_CTRL    = 1;
    localparam int unsigned A_TC      = 2;
    localparam int unsigned A_PR      = 3;
    localparam int unsigned A_PC      = 4;
    localparam int unsigned A_MCR     = 5;
    localparam int unsigned A_MR_BASE = 8;

    localparam int unsigned ACT_PER_MATCH = 3;
    localparam int unsigned ACT_INT  = 0;
    localparam int unsigned ACT_RST  = 1;
    localparam int unsigned ACT_STOP = 2;

    localparam int unsigned CTRL_EN  = 0;
    localparam int unsigned CTRL_CLR = 1;
endpackage

// File: rtl/mtmr_prescaler.sv
// Prescale counter. Counts clocks while enabled and emits a one-clock tick
// when its value is at or above the prescale limit, then wraps to zero.
// Assumes the clear input overrides bus writes and that bus writes override counting.
module mtmr_prescaler #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    input  logic             wr_load,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] pc,
    output logic             tick
);
    // Tick when the limit is reached; a load in the same cycle suppresses it.
    assign tick = run && !clr && !wr_load && (pc >= limit);

    // Prescale count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (clr) begin
            pc <= '0;
        end else if (wr_load) begin
            pc <= wr_data;
        end else if (tick) begin
            pc <= '0;
        end else if (run) begin
            pc <= pc + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mtmr_counter.sv
// Timer counter. Steps once per prescale tick. A restart request loads
// zero and a halt request holds the value. Assumes at most one tick per clock.
module mtmr_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             hit_rst,
    input  logic             hit_stop,
    input  logic             wr_load,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] tc
);
    // Timer count register; priority is clear, bus load, then the tick actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= '0;
        end else if (clr) begin
            tc <= '0;
        end else if (wr_load) begin
            tc <= wr_data;
        end else if (tick) begin
            if (hit_rst) begin
                tc <= '0;
            end else if (!hit_stop) begin
                tc <= tc + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/mtmr_match_bank.sv
// Compare bank. For each match register it detects a tick while the timer
// equals the register. It registers the event as a strobe and latches an
// interrupt flag when the action bit enables it. It also merges the restart
// and halt requests. Assumes the action bits are laid out three per match.
module mtmr_match_bank
    import mtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_MATCH = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic [CNT_W-1:0]                tc,
    input  logic [N_MATCH-1:0][CNT_W-1:0]   mr,
    input  logic [ACT_PER_MATCH*N_MATCH-1:0] mcr,
    input  logic [N_MATCH-1:0]              clr_mask,
    output logic [N_MATCH-1:0]              pulse,
    output logic [N_MATCH-1:0]              flags,
    output logic                            hit_rst,
    output logic                            hit_stop
);
    logic [N_MATCH-1:0] hit;
    logic [N_MATCH-1:0] rst_req;
    logic [N_MATCH-1:0] stop_req;
    logic [N_MATCH-1:0] int_req;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
        // Per-match event and the actions it requests.
        assign hit[i]      = tick && (tc == mr[i]);
        assign int_req[i]  = hit[i] && mcr[ACT_PER_MATCH*i + ACT_INT];
        assign rst_req[i]  = hit[i] && mcr[ACT_PER_MATCH*i + ACT_RST];
        assign stop_req[i] = hit[i] && mcr[ACT_PER_MATCH*i + ACT_STOP];
    end

    assign hit_rst  = |rst_req;
    assign hit_stop = |stop_req;

    // Registered event strobes, one clock wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= '0;
        end else begin
            pulse <= hit;
        end
    end

    // Pending flags: write-one-to-clear, with a new event taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | int_req;
        end
    end
endmodule

// File: rtl/mtmr_regfile.sv
// Register file and bus decoder. Holds control, prescale, match-control and
// match registers, produces write strobes for the counters and the flag
// clear mask, and muxes read data. Assumes 3*N_MATCH <= CNT_W.
module mtmr_regfile
    import mtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_MATCH = 7,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [CNT_W-1:0]                 bus_wdata,
    input  logic                             hit_stop,
    input  logic [CNT_W-1:0]                 tc,
    input  logic [CNT_W-1:0]                 pc,
    input  logic [N_MATCH-1:0]               flags,
    output logic                             cnt_en,
    output logic                             cnt_clr,
    output logic [CNT_W-1:0]                 pr,
    output logic [ACT_PER_MATCH*N_MATCH-1:0] mcr,
    output logic [N_MATCH-1:0][CNT_W-1:0]    mr,
    output logic [CNT_W-1:0]                 rdata,
    output logic                             wr_tc,
    output logic                             wr_pc,
    output logic [N_MATCH-1:0]               clr_mask
);
    localparam int unsigned MCR_W = ACT_PER_MATCH * N_MATCH;

    logic       wr;
    logic       wr_ctrl;
    logic       wr_pr;
    logic       wr_mcr;
    logic       wr_flags;
    logic [1:0] ctrl_q;

    assign wr       = bus_sel && bus_wr;
    assign wr_ctrl  = wr && (bus_addr == ADDR_W'(A_CTRL));
    assign wr_pr    = wr && (bus_addr == ADDR_W'(A_PR));
    assign wr_mcr   = wr && (bus_addr == ADDR_W'(A_MCR));
    assign wr_flags = wr && (bus_addr == ADDR_W'(A_FLAGS));
    assign wr_tc    = wr && (bus_addr == ADDR_W'(A_TC));
    assign wr_pc    = wr && (bus_addr == ADDR_W'(A_PC));
    assign clr_mask = wr_flags ? bus_wdata[N_MATCH-1:0] : '0;

    assign cnt_en  = ctrl_q[CTRL_EN];
    assign cnt_clr = ctrl_q[CTRL_CLR];

    // Control register; a halt event drops the enable unless the bus writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata[1:0];
        end else if (hit_stop) begin
            ctrl_q[CTRL_EN] <= 1'b0;
        end
    end

    // Prescale limit and match-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr  <= '0;
            mcr <= '0;
        end else begin
            if (wr_pr)  pr  <= bus_wdata;
            if (wr_mcr) mcr <= bus_wdata[MCR_W-1:0];
        end
    end

    for (genvar i = 0; i < N_MATCH; i++) begin : g_mr
        logic wr_mr;
        assign wr_mr = wr && (bus_addr == ADDR_W'(A_MR_BASE + i));
        // Match value register i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mr[i] <= '0;
            end else if (wr_mr) begin
                mr[i] <= bus_wdata;
            end
        end
    end

    // Read data mux; zero when the bus is idle or the word is unmapped.
    always_comb begin
        rdata = '0;
        case (bus_addr)
            ADDR_W'(A_FLAGS): rdata = CNT_W'(flags);
            ADDR_W'(A_CTRL):  rdata = CNT_W'(ctrl_q);
            ADDR_W'(A_TC):    rdata = tc;
            ADDR_W'(A_PR):    rdata = pr;
            ADDR_W'(A_PC):    rdata = pc;
            ADDR_W'(A_MCR):   rdata = CNT_W'(mcr);
            default:          rdata = '0;
        endcase
        for (int i = 0; i < N_MATCH; i++) begin
            if (bus_addr == ADDR_W'(A_MR_BASE + i)) rdata = mr[i];
        end
        if (!bus_sel || bus_wr) rdata = '0;
    end
endmodule

// File: rtl/match_timer.sv
// Top of the prescaled match timer. It connects the register file, the
// prescaler, the timer counter and the compare bank. The interrupt output
// is the OR of the pending flags. Assumes a synchronous active-low reset.
module match_timer
    import mtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_MATCH = 7,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic               irq,
    output logic [N_MATCH-1:0] match_pulse
);
    localparam int unsigned MCR_W = ACT_PER_MATCH * N_MATCH;

    logic                          cnt_en;
    logic                          cnt_clr;
    logic [CNT_W-1:0]              pr_q;
    logic [MCR_W-1:0]              mcr_q;
    logic [N_MATCH-1:0][CNT_W-1:0] mr_q;
    logic [CNT_W-1:0]              tc_q;
    logic [CNT_W-1:0]              pc_q;
    logic [N_MATCH-1:0]            flags_q;
    logic [N_MATCH-1:0]            clr_mask;
    logic                          wr_tc;
    logic                          wr_pc;
    logic                          tick;
    logic                          hit_rst;
    logic                          hit_stop;

    mtmr_regfile #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .hit_stop(hit_stop), .tc(tc_q), .pc(pc_q), .flags(flags_q),
        .cnt_en(cnt_en), .cnt_clr(cnt_clr), .pr(pr_q), .mcr(mcr_q), .mr(mr_q),
        .rdata(bus_rdata), .wr_tc(wr_tc), .wr_pc(wr_pc), .clr_mask(clr_mask)
    );

    mtmr_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(cnt_en), .clr(cnt_clr), .limit(pr_q),
        .wr_load(wr_pc), .wr_data(bus_wdata), .pc(pc_q), .tick(tick)
    );

    mtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
        .hit_rst(hit_rst), .hit_stop(hit_stop),
        .wr_load(wr_tc), .wr_data(bus_wdata), .tc(tc_q)
    );

    mtmr_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tc(tc_q), .mr(mr_q), .mcr(mcr_q),
        .clr_mask(clr_mask), .pulse(match_pulse), .flags(flags_q),
        .hit_rst(hit_rst), .hit_stop(hit_stop)
    );

    // Interrupt line: any pending flag.
    assign irq = |flags_q;
endmodule

// File: rtl/mtmr_checker.sv
// Property checker for match_timer, attached through bind. It observes the
// bus ports and the internal counter, control and flag state.
module mtmr_checker
    import mtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_MATCH = 7,
    parameter int unsigned ADDR_W  = 5
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_sel,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [CNT_W-1:0]                 tc,
    input logic [CNT_W-1:0]                 pc,
    input logic                             en,
    input logic                             crst,
    input logic [ACT_PER_MATCH*N_MATCH-1:0] mcr,
    input logic [N_MATCH-1:0]               flags,
    input logic [N_MATCH-1:0]               pulse
);
    logic               w_tc, w_pc, w_ctrl, w_mcr;
    logic [N_MATCH-1:0] int_en, rst_en, stop_en;

    assign w_tc   = bus_sel && bus_wr && (bus_addr == ADDR_W'(A_TC));
    assign w_pc   = bus_sel && bus_wr && (bus_addr == ADDR_W'(A_PC));
    assign w_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    assign w_mcr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(A_MCR));

    always_comb begin
        for (int i = 0; i < N_MATCH; i++) begin
            int_en[i]  = mcr[ACT_PER_MATCH*i + ACT_INT];
            rst_en[i]  = mcr[ACT_PER_MATCH*i + ACT_RST];
            stop_en[i] = mcr[ACT_PER_MATCH*i + ACT_STOP];
        end
    end

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        crst |=> (tc == '0 && pc == '0));

    a_r3_idle_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !crst && !w_tc) |=> $stable(tc));

    a_r3_idle_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !crst && !w_pc) |=> $stable(pc));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!crst && !w_tc) |=> (tc == $past(tc) || tc == $past(tc) + CNT_W'(1) || tc == '0));

    a_r7_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pulse & int_en) && !$past(w_mcr)) |-> ((pulse & int_en & ~flags) == '0));

    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pulse & rst_en) && !$past(w_mcr) && !$past(w_tc) && !$past(crst)) |-> (tc == '0));

    a_r10_halt_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pulse & stop_en) && !$past(w_mcr) && !$past(w_ctrl)) |-> !en);
endmodule

bind match_timer mtmr_checker #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .tc(tc_q), .pc(pc_q), .en(cnt_en), .crst(cnt_clr), .mcr(mcr_q),
    .flags(flags_q), .pulse(match_pulse)
);

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;
    localparam int ADDR_W = 5;
    // Vector columns: prescale, match0, match-control, enabled edges, expected timer, expected prescale.
    localparam int unsigned VEC [0:7][0:5] = '{
        '{0, 0, 0, 10, 10, 0},
        '{3, 0, 0, 10,  2, 2},
        '{4, 0, 0, 23,  4, 3},
        '{1, 3, 2, 11,  1, 1},
        '{0, 5, 4, 20,  5, 0},
        '{2, 2, 4,  5,  1, 2},
        '{0, 0, 2,  7,  0, 0},
        '{2, 1, 6, 30,  0, 0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;
    logic [6:0]        match_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    match_timer i_match_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .match_pulse(match_pulse)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d, d2;
        int npulse, at;
        run(3);
        rst_n = 1'b1;

        // R1: reset state on every mapped word and on the outputs
        for (int a = 0; a < 15; a++) begin
            rd(a, d);
            check($sformatf("R1 word %0d", a), d, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 match_pulse", {25'b0, match_pulse}, 32'h0);

        // R2 R9 R10: vector table, each run from a cleared timer
        for (int v = 0; v < 8; v++) begin
            wr(1, 32'd2);
            wr(3, VEC[v][0]);
            wr(8, VEC[v][1]);
            wr(5, VEC[v][2]);
            wr(0, 32'h7F);
            wr(1, 32'd1);
            run(int'(VEC[v][3]));
            rd(2, d);
            check($sformatf("R2/R9/R10 vec%0d timer", v), d, VEC[v][4]);
            rd(4, d);
            check($sformatf("R2/R9/R10 vec%0d prescale", v), d, VEC[v][5]);
        end
        // R10: last vector halted, so the enable bit is clear
        rd(1, d);
        check("R10 enable cleared by halt", d, 32'h0);

        // R5: load both counters while stopped, then wrap the timer
        wr(1, 32'd0);
        wr(5, 32'd0);
        wr(3, 32'd9);
        wr(2, 32'hFFFF_FFFE);
        wr(4, 32'd7);
        rd(2, d);
        check("R5 timer load", d, 32'hFFFF_FFFE);
        rd(4, d);
        check("R5 prescale load", d, 32'd7);
        wr(1, 32'd1);
        run(3);
        rd(2, d);
        check("R2 step from loaded prescale", d, 32'hFFFF_FFFF);
        run(10);
        rd(2, d);
        check("R2 timer wrap", d, 32'h0);

        // R3: disable and verify both counters hold
        wr(1, 32'd0);
        run(20);
        rd(2, d);
        rd(4, d2);
        check("R3 timer held", d, 32'h0);
        check("R3 prescale held", d2, 32'd1);

        // R4: counter clear overrides a bus write
        wr(1, 32'd3);
        wr(2, 32'd77);
        run(5);
        rd(2, d);
        rd(4, d2);
        check("R4 timer zero", d, 32'h0);
        check("R4 prescale zero", d2, 32'h0);

        // R6 R7: match 2 at value 4, prescale 3 -> event at edge 20 after enable
        wr(1, 32'd2);
        wr(3, 32'd3);
        wr(10, 32'd4);
        wr(5, 32'h40);
        wr(0, 32'h7F);
        wr(1, 32'd1);
        npulse = 0; at = 0;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            if (match_pulse[2]) begin npulse++; at = k; end
        end
        check("R6 strobe count", npulse, 32'd1);
        check("R6 strobe cycle", at, 32'd20);
        rd(0, d);
        check("R7 flag bit 2", d, 32'h4);
        check("R7 irq high", {31'b0, irq}, 32'h1);

        // R8: writing zero to the flag bit leaves it pending
        wr(0, 32'h1);
        rd(0, d);
        check("R8 clear other bit only", d, 32'h4);
        wr(0, 32'h4);
        rd(0, d);
        check("R8 cleared", d, 32'h0);
        check("R8 irq low", {31'b0, irq}, 32'h0);

        // R8: a clear at the event edge loses to the new event
        wr(1, 32'd2);
        wr(1, 32'd1);
        run(19);
        wr(0, 32'h4);
        rd(0, d);
        check("R8 set wins over clear", d, 32'h4);

        // R11: unused bits and unmapped words
        wr(6, 32'h1234);
        rd(6, d);
        check("R11 unmapped word", d, 32'h0);
        wr(5, 32'hFFFF_FFFF);
        rd(5, d);
        check("R11 match-control width", d, 32'h001F_FFFF);
        wr(1, 32'hFFFF_FFFF);
        rd(1, d);
        check("R11 control width", d, 32'h3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule